// File: doc/BRIEF.md
# Matrix Keypad Scanner with Debounce

The block reads a key matrix of up to eight rows and eight columns through sixteen pins. It pulls one row low at a time, waits a programmable settle time, and reads the column lines. Each column line is pulled high, so a closed key reads low. One complete pass over the enabled rows is a scan frame. From each frame the block forms a summary: whether any key is down, the code of the first key found, and whether more than one key is down.

That summary goes through a debounce filter. The filter accepts a new summary only after it has stayed unchanged for a programmable number of clock cycles. The same rule applies to presses and to releases.

A confirmed press produces a one-cycle report. The report carries the key code, a per-key press count and a multi-key flag. It also sets an interrupt request, which stays pending until a clear pulse arrives. In single-press mode each separate press is reported once. In hold mode a held key is reported again at a fixed interval, and each repeat adds one to its count. Configuration is a set of static inputs that are meant to change only while no key is down.

Top module: `keypad_scanner`

## Requirements
- R1: Exactly one row output is low at any time. Rows are driven in ascending order from 0 up to `cfg_rows`, and a row above `cfg_rows` is never driven low.
- R2: A column reads as pressed when it is low. Columns above `cfg_cols` and rows above `cfg_rows` are never reported.
- R3: A report is a one-cycle `key_valid` pulse. `key_code[5:3]` holds the row index and `key_code[2:0]` holds the column index.
- R4: A change in the scan summary is accepted only after it has stayed stable for `cfg_debounce` cycles. A press shorter than that is never reported.
- R5: A release is accepted only after the key has read up for the full debounce width. A shorter gap in the contact does not produce a new report.
- R6: With `cfg_mode`=0 a held key is reported once. A press, release and press of the same key gives counts 1 and then 2. A press of a different key restarts the count at 1.
- R7: With `cfg_mode`=1 a held key is reported again every `cfg_hold` cycles, and its count rises by one each time.
- R8: When two or more keys are down in one frame, `key_multi` is 1 and the code is that of the lowest row. Within that row it is the lowest column. With a single key down, `key_multi` is 0.
- R9: `irq` goes high together with each report and stays high until `irq_clr` is pulsed. If a report and a clear arrive in the same cycle, the report wins.
- R10: After reset, `irq` and `key_valid` are 0 and row 0 is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_n | input | 8 | Column sense lines, low = key closed |
| cfg_rows | input | 3 | Highest enabled row index |
| cfg_cols | input | 3 | Highest enabled column index |
| cfg_settle | input | 8 | Extra cycles a row is held before its columns are sampled |
| cfg_debounce | input | 16 | Stability width in cycles |
| cfg_mode | input | 1 | 0 = single press, 1 = press and hold |
| cfg_hold | input | 16 | Repeat interval in cycles for hold mode |
| irq_clr | input | 1 | Pulse to clear the pending interrupt |
| row_n | output | 8 | Row drive lines, low = selected |
| key_valid | output | 1 | One-cycle report strobe |
| key_code | output | 6 | Reported key, row in [5:3], column in [2:0] |
| key_count | output | 8 | Press count of the reported key |
| key_multi | output | 1 | Several keys were down in the reported frame |
| irq | output | 1 | Pending interrupt request |

## Verification
The bench builds the block with its default parameters, which give the full eight by eight matrix. At run time it uses a settle of one cycle and a debounce width of 20 cycles. A scan frame then lasts 16 cycles, so all 64 key positions can be swept one after another in a few thousand cycles. The debounce width sits above one frame period, so a press or a gap that lasts a single frame can be made to fall below the filter width.

A four by four setting shows the row and column limits. A 50-cycle hold interval lets the repeat spacing be measured to the exact cycle.

// File: rtl/keypad_pkg.sv
// Shared widths and the per-frame summary type for the keypad scanner.
// Assumes a matrix of at most 8 x 8 so that a key code fits in six bits.
package keypad_pkg;
    localparam int unsigned KP_ROWS   = 8;
    localparam int unsigned KP_COLS   = 8;
    localparam int unsigned KP_ROW_W  = $clog2(KP_ROWS);
    localparam int unsigned KP_COL_W  = $clog2(KP_COLS);
    localparam int unsigned KP_CODE_W = KP_ROW_W + KP_COL_W;

    // Debounced or raw view of one scan frame
    typedef struct packed {
        logic                 down;
        logic                 multi;
        logic [KP_CODE_W-1:0] code;
    } kp_frame_t;
endpackage

// File: rtl/kp_scan_seq.sv
// Scan sequencer: pulls one row low at a time and waits cfg_settle cycles.
// It then samples the active-low columns and builds a summary for each frame.
// Assumes the column lines are pulled high outside the block.
module kp_scan_seq
    import keypad_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [KP_COLS-1:0]  col_n,
    input  logic [KP_ROW_W-1:0] cfg_rows,
    input  logic [KP_COL_W-1:0] cfg_cols,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic [KP_ROWS-1:0]  row_n,
    output logic                frame_valid,
    output kp_frame_t           frame
);
    logic [KP_ROW_W-1:0] row_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [1:0]          acc_cnt_q;
    logic                acc_found_q;
    logic [KP_CODE_W-1:0] acc_code_q;

    logic [KP_COLS-1:0]  col_mask;
    logic [KP_COLS-1:0]  hits;
    logic [KP_COL_W-1:0] low_col;
    logic [1:0]          row_cnt;
    logic [1:0]          base_cnt;
    logic                base_found;
    logic [2:0]          sum_cnt;
    logic [1:0]          new_cnt;
    logic                new_found;
    logic [KP_CODE_W-1:0] new_code;

    // Row decode: drive the selected row low, all others high
    for (genvar r = 0; r < KP_ROWS; r++) begin : g_row
        assign row_n[r] = (row_q != KP_ROW_W'(r));
    end

    // Column enable: only indices up to cfg_cols take part
    for (genvar c = 0; c < KP_COLS; c++) begin : g_col
        assign col_mask[c] = (KP_COL_W'(c) <= cfg_cols);
    end

    assign hits = ~col_n & col_mask;

    // Lowest closed column and a saturating count of closed columns
    always_comb begin
        low_col = '0;
        row_cnt = 2'd0;
        for (int i = KP_COLS - 1; i >= 0; i--) begin
            if (hits[i]) low_col = KP_COL_W'(i);
        end
        for (int i = 0; i < KP_COLS; i++) begin
            if (hits[i] && row_cnt != 2'd2) row_cnt = row_cnt + 2'd1;
        end
    end

    // Merge this row's result into what the frame has gathered so far
    always_comb begin
        base_cnt   = (row_q == '0) ? 2'd0 : acc_cnt_q;
        base_found = (row_q == '0) ? 1'b0 : acc_found_q;
        sum_cnt    = {1'b0, base_cnt} + {1'b0, row_cnt};
        new_cnt    = (sum_cnt >= 3'd2) ? 2'd2 : sum_cnt[1:0];
        new_found  = base_found || (hits != '0);
        new_code   = base_found ? acc_code_q : {row_q, low_col};
    end

    // Step the settle counter and the row index, and publish the frame summary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q       <= '0;
            settle_q    <= '0;
            acc_cnt_q   <= 2'd0;
            acc_found_q <= 1'b0;
            acc_code_q  <= '0;
            frame_valid <= 1'b0;
            frame       <= '0;
        end else begin
            frame_valid <= 1'b0;
            if (row_q > cfg_rows) begin
                row_q    <= '0;
                settle_q <= '0;
            end else if (settle_q < cfg_settle) begin
                settle_q <= settle_q + 1'b1;
            end else begin
                settle_q    <= '0;
                acc_cnt_q   <= new_cnt;
                acc_found_q <= new_found;
                acc_code_q  <= new_code;
                if (row_q == cfg_rows) begin
                    row_q       <= '0;
                    frame_valid <= 1'b1;
                    frame.down  <= new_found;
                    frame.multi <= (new_cnt == 2'd2);
                    frame.code  <= new_found ? new_code : '0;
                end else begin
                    row_q <= row_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/kp_debounce.sv
// Debounce filter: takes a new frame summary as confirmed once it has stayed
// unchanged for cfg_debounce cycles. Presses and releases follow the same rule.
// It pulses press_evt when a key becomes down or the down key changes.
module kp_debounce
    import keypad_pkg::*;
#(
    parameter int unsigned DB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_valid,
    input  kp_frame_t       frame,
    input  logic [DB_W-1:0] cfg_debounce,
    output kp_frame_t       conf,
    output logic            press_evt
);
    kp_frame_t       cand_q;
    logic [DB_W-1:0] stable_q;
    logic            differs;

    assign differs = frame_valid && (frame != cand_q);

    // Track the candidate state, its age, and promote it once stable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= '0;
            stable_q  <= '0;
            conf      <= '0;
            press_evt <= 1'b0;
        end else begin
            press_evt <= 1'b0;
            if (differs) begin
                cand_q   <= frame;
                stable_q <= '0;
            end else begin
                if (stable_q != '1) stable_q <= stable_q + 1'b1;
                if (stable_q >= cfg_debounce && cand_q != conf) begin
                    conf      <= cand_q;
                    press_evt <= cand_q.down &&
                                 (!conf.down || cand_q.code != conf.code);
                end
            end
        end
    end
endmodule

// File: rtl/kp_report.sv
// Report unit: turns confirmed presses into reports with a per-key count and
// keeps the sticky interrupt. In hold mode it repeats a held key every cfg_hold
// cycles. The interval counter restarts on a new press and rests while no key is down.
module kp_report
    import keypad_pkg::*;
#(
    parameter int unsigned HOLD_W  = 16,
    parameter int unsigned COUNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  kp_frame_t            conf,
    input  logic                 press_evt,
    input  logic                 cfg_mode,
    input  logic [HOLD_W-1:0]    cfg_hold,
    input  logic                 irq_clr,
    output logic                 key_valid,
    output logic [KP_CODE_W-1:0] key_code,
    output logic [COUNT_W-1:0]   key_count,
    output logic                 key_multi,
    output logic                 irq
);
    logic [HOLD_W-1:0] hold_q;
    logic              have_last_q;
    logic              hold_due;
    logic              fire;

    assign hold_due = cfg_mode && conf.down && !press_evt &&
                      ({1'b0, hold_q} + 1'b1 >= {1'b0, cfg_hold});
    assign fire     = press_evt || hold_due;

    // Hold interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (fire || !conf.down) begin
            hold_q <= '0;
        end else if (hold_q != '1) begin
            hold_q <= hold_q + 1'b1;
        end
    end

    // Report registers and per-key press count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_valid   <= 1'b0;
            key_code    <= '0;
            key_count   <= '0;
            key_multi   <= 1'b0;
            have_last_q <= 1'b0;
        end else begin
            key_valid <= fire;
            if (fire) begin
                key_code    <= conf.code;
                key_multi   <= conf.multi;
                have_last_q <= 1'b1;
                if (have_last_q && conf.code == key_code) begin
                    if (key_count != '1) key_count <= key_count + 1'b1;
                end else begin
                    key_count <= COUNT_W'(1);
                end
            end
        end
    end

    // Sticky interrupt: a report sets it, a clear pulse drops it
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (fire)    irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end
endmodule

// File: rtl/keypad_scanner.sv
// Top level of the matrix keypad scanner: sequencer, debounce filter, report unit.
// Configuration inputs are assumed static while any key is down.
module keypad_scanner
    import keypad_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8,
    parameter int unsigned DB_W     = 16,
    parameter int unsigned HOLD_W   = 16,
    parameter int unsigned COUNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [KP_COLS-1:0]   col_n,
    input  logic [KP_ROW_W-1:0]  cfg_rows,
    input  logic [KP_COL_W-1:0]  cfg_cols,
    input  logic [SETTLE_W-1:0]  cfg_settle,
    input  logic [DB_W-1:0]      cfg_debounce,
    input  logic                 cfg_mode,
    input  logic [HOLD_W-1:0]    cfg_hold,
    input  logic                 irq_clr,
    output logic [KP_ROWS-1:0]   row_n,
    output logic                 key_valid,
    output logic [KP_CODE_W-1:0] key_code,
    output logic [COUNT_W-1:0]   key_count,
    output logic                 key_multi,
    output logic                 irq
);
    logic      frame_valid;
    kp_frame_t frame;
    kp_frame_t conf;
    logic      press_evt;

    kp_scan_seq #(.SETTLE_W(SETTLE_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .col_n(col_n),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_settle(cfg_settle),
        .row_n(row_n), .frame_valid(frame_valid), .frame(frame)
    );

    kp_debounce #(.DB_W(DB_W)) u_db (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame(frame),
        .cfg_debounce(cfg_debounce), .conf(conf), .press_evt(press_evt)
    );

    kp_report #(.HOLD_W(HOLD_W), .COUNT_W(COUNT_W)) u_rep (
        .clk(clk), .rst_n(rst_n), .conf(conf), .press_evt(press_evt),
        .cfg_mode(cfg_mode), .cfg_hold(cfg_hold), .irq_clr(irq_clr),
        .key_valid(key_valid), .key_code(key_code), .key_count(key_count),
        .key_multi(key_multi), .irq(irq)
    );
endmodule

// File: rtl/keypad_scanner_chk.sv
// Property checker for keypad_scanner. It is attached with bind and observes ports only.
module keypad_scanner_chk
    import keypad_pkg::*;
#(
    parameter int unsigned COUNT_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [KP_ROWS-1:0]   row_n,
    input logic                 cfg_mode,
    input logic                 irq_clr,
    input logic                 key_valid,
    input logic [COUNT_W-1:0]   key_count,
    input logic                 irq
);
    // R1
    one_row_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n) == 1);

    // R3
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_valid && !cfg_mode) |=> !key_valid);

    // R6
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_count != '0);

    // R9
    irq_with_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> irq);

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> (irq == key_valid));
endmodule

bind keypad_scanner keypad_scanner_chk #(.COUNT_W(COUNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_n(row_n), .cfg_mode(cfg_mode),
    .irq_clr(irq_clr), .key_valid(key_valid), .key_count(key_count), .irq(irq)
);

// File: tb/sim_keypad_scanner.sv
// Self-checking bench: models the key matrix and sweeps keys, limits and modes.
module sim_keypad_scanner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  col_n;
    logic [2:0]  cfg_rows = 3'd7;
    logic [2:0]  cfg_cols = 3'd7;
    logic [7:0]  cfg_settle = 8'd1;
    logic [15:0] cfg_debounce = 16'd20;
    logic        cfg_mode = 1'b0;
    logic [15:0] cfg_hold = 16'd50;
    logic        irq_clr = 1'b0;
    logic [7:0]  row_n;
    logic        key_valid;
    logic [5:0]  key_code;
    logic [7:0]  key_count;
    logic        key_multi;
    logic        irq;

    logic [63:0] keys = '0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    keypad_scanner u0 (
        .clk(clk), .rst_n(rst_n), .col_n(col_n), .cfg_rows(cfg_rows),
        .cfg_cols(cfg_cols), .cfg_settle(cfg_settle), .cfg_debounce(cfg_debounce),
        .cfg_mode(cfg_mode), .cfg_hold(cfg_hold), .irq_clr(irq_clr),
        .row_n(row_n), .key_valid(key_valid), .key_code(key_code),
        .key_count(key_count), .key_multi(key_multi), .irq(irq)
    );

    // Matrix model: a closed key pulls its column low while its row is driven low
    always_comb begin
        col_n = '1;
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                if (keys[r*8+c] && !row_n[r]) col_n[c] = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Wait up to n cycles for a report
    task automatic wait_rep(input int n, output bit found);
        found = 0;
        for (int i = 0; i < n && !found; i++) begin
            @(negedge clk);
            if (key_valid) found = 1;
        end
    endtask

    task automatic press_check(input int idx, input int exp_cnt, input string req);
        bit f;
        keys = '0;
        keys[idx] = 1'b1;
        wait_rep(200, f);
        chk(f, req, int'(f), 1);
        chk(key_code == 6'(idx), req, key_code, idx);
        chk(key_count == 8'(exp_cnt), req, key_count, exp_cnt);
        chk(!key_multi, "R8", key_multi, 0);
        keys = '0;
        idle(100);
    endtask

    initial begin
        int bad;
        int n;
        bit f;
        idle(3);
        // R10 reset state
        chk(!irq && !key_valid, "R10", {irq, key_valid}, 0);
        chk(row_n == 8'hFE, "R10", row_n, 8'hFE);
        rst_n = 1'b1;
        idle(40);
        chk(!irq, "R10", irq, 0);

        // R3 R2: sweep every key of the full matrix
        for (int k = 0; k < 64; k++) press_check(k, 1, "R3");

        // R9 pending until cleared
        chk(irq, "R9", irq, 1);
        idle(50);
        chk(irq, "R9", irq, 1);
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
        chk(!irq, "R9", irq, 0);

        // R6 press-release-press of the same key, then a different key
        press_check(18, 1, "R6");
        press_check(18, 2, "R6");
        press_check(18, 3, "R6");
        press_check(40, 1, "R6");

        // R6 a held key in single-press mode is reported once
        keys = '0; keys[33] = 1'b1;
        wait_rep(200, f);
        chk(f && key_code == 6'd33, "R6", key_code, 33);
        wait_rep(400, f);
        chk(!f, "R6", int'(f), 0);
        keys = '0; idle(100);

        // R4 a bounce shorter than the debounce width is ignored
        for (int t = 0; t < 4; t++) begin
            keys = '0; keys[9] = 1'b1; idle(10);
            keys = '0;
            wait_rep(150, f);
            chk(!f, "R4", int'(f), 0);
        end

        // R5 a short gap while held does not give a second press
        keys = '0; keys[12] = 1'b1;
        wait_rep(200, f);
        chk(f && key_count == 8'd1, "R5", key_count, 1);
        keys = '0; idle(10); keys[12] = 1'b1;
        wait_rep(200, f);
        chk(!f, "R5", int'(f), 0);
        keys = '0; idle(100);
        press_check(12, 2, "R5");

        // R8 several keys down: lowest row first, then lowest column
        keys = '0; keys[1*8+2] = 1'b1; keys[3*8+0] = 1'b1;
        wait_rep(200, f);
        chk(f && key_multi, "R8", key_multi, 1);
        chk(key_code == 6'd10, "R8", key_code, 10);
        keys = '0; idle(100);
        keys[2*8+5] = 1'b1; keys[2*8+1] = 1'b1;
        wait_rep(200, f);
        chk(f && key_multi, "R8", key_multi, 1);
        chk(key_code == 6'd17, "R8", key_code, 17);
        keys = '0; idle(100);

        // R7 hold mode: repeats every cfg_hold cycles with a rising count
        cfg_mode = 1'b1;
        keys = '0; keys[5] = 1'b1;
        wait_rep(200, f);
        chk(f && key_count == 8'd1, "R7", key_count, 1);
        for (int rep = 2; rep <= 4; rep++) begin
            n = 0;
            f = 0;
            while (!f && n < 500) begin
                @(negedge clk); n++;
                if (key_valid) f = 1;
            end
            chk(n == 50, "R7", n, 50);
            chk(key_count == 8'(rep) && key_code == 6'd5, "R7", key_count, rep);
        end
        keys = '0; idle(100);
        wait_rep(200, f);
        chk(!f, "R7", int'(f), 0);
        cfg_mode = 1'b0;

        // R1 R2 limited matrix of 4 x 4
        cfg_rows = 3'd3; cfg_cols = 3'd3;
        idle(20);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (row_n[7:4] != 4'hF || $countones(~row_n) != 1) bad++;
        end
        chk(bad == 0, "R1", bad, 0);
        keys = '0; keys[5*8+1] = 1'b1;
        wait_rep(300, f);
        chk(!f, "R2", int'(f), 0);
        keys = '0; keys[1*8+6] = 1'b1;
        wait_rep(300, f);
        chk(!f, "R2", int'(f), 0);
        keys = '0; idle(100);
        press_check(2*8+3, 1, "R2");
        cfg_rows = 3'd7; cfg_cols = 3'd7;
        idle(40);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule